// File: doc/BRIEF.md
# Serial Port Register Block

This block is the bus-facing side of a small 8N1 serial port. A host reaches it through a simple synchronous bus with byte-wide data. The register slots are one 32-bit word apart, but each holds only eight bits. There are eight slots:

- four read-only identification bytes;
- a data port;
- a mixed status/control byte;
- the low and high halves of a 16-bit baud divisor.

Received bytes come in over a valid/ready stream from a deserializer and wait in a small FIFO. Each host read of the data port takes one byte out of that FIFO.

On the transmit side, a host write to the data port lands in a one-byte holding stage. A shifter then sends it out as a serial frame on `txd`. Receive and transmit events drive a single interrupt line.

The status byte holds three kinds of bit:

- two interrupt enables, which the host can read and write;
- four FIFO and holding flags, which are read-only;
- two sticky receive error flags. The host clears these by writing a zero to them.

The receive stream follows these back-pressure rules. `rx_ready` is low exactly while the FIFO is full. A source may hold `rx_valid` high while `rx_ready` is low. A byte offered in such a cycle is dropped and the overrun flag is set, because a line receiver cannot stall.

Top module: `serial_port_regs`

## Requirements
- R1: Slots at byte offsets 0, 4, 8 and 12 return bytes 0 to 3 of the `ID_WORD` parameter (offset 0 gives bits 7:0) and ignore writes. A read presents its data on `bus_rdata` after the clock edge that samples `bus_rd`, and `bus_rdata` holds its value when no read is made.
- R2: The baud divisor is written and read back as a low byte at offset 24 and a high byte at offset 28. It resets to zero.
- R3: The status byte at offset 20 reports the receive FIFO state in three bits: bit3 set when full, bit4 set when exactly one free entry remains, bit5 set when empty. Host writes to bits 3, 4, 5 and 7 have no effect.
- R4: A read of the data port at offset 16 pops the oldest received byte, in arrival order. A read while the FIFO is empty returns the last popped byte and leaves the FIFO empty.
- R5: `rx_ready` is low exactly when the FIFO is full. A byte offered with `rx_valid` high while `rx_ready` is low is dropped and sets the overrun flag (status bit1).
- R6: A byte accepted with `rx_frame_bad` high is stored and sets the frame error flag (status bit0). Writing the status byte with an error bit at 0 clears that flag; writing it at 1 leaves the flag unchanged.
- R7: Status bit7 is 1 while the transmit holding stage is empty. A data-port write is taken only in that case; a write while the stage is full is dropped.
- R8: The `txd` line idles high. Each frame consists of a low start bit, then eight data bits LSB first, then a high stop bit. Each bit lasts 4*(divisor+1) clocks.
- R9: `irq` is high when receive enable (status bit2) is set and the FIFO is non-empty or an error flag is set. It is also high when transmit enable (status bit6) is set and the holding stage is empty.
- R10: After reset, both interrupt enables and both error flags are 0, so the status byte reads 0xA0, `irq` is low and `txd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte address; slots are word aligned |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the strobe |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | FIFO can take a byte |
| rx_byte | input | 8 | Received byte |
| rx_frame_bad | input | 1 | Stop bit missing on the offered byte |
| irq | output | 1 | Combined receive/transmit interrupt |
| txd | output | 1 | Serial transmit line |

## Verification
Register reads are due on the falling edge after the rising edge that samples the strobe. The bench's bus tasks read `bus_rdata` exactly there.

Flag, `rx_ready` and `irq` changes caused by a push or a status write appear after the single edge that accepts the stimulus. The bench checks them at the next falling edge.

An accepted data-port write reaches the holding stage on its edge. When the shifter is idle, the shifter loads the byte one edge later, and `txd` drops at that edge. After that, each bit lasts 4*(divisor+1) clocks.

The scoreboard monitor detects the falling start edge. It then samples `txd` at the middle of every bit period and compares each decoded frame with the queue that the driver filled. A wrong bit period or bit order therefore lands the sample on the wrong bit.

// File: rtl/sprt_pkg.sv
package sprt_pkg;
  localparam int ADDR_W = 5;
  localparam int BYTE_W = 8;

  // word slot index = byte address / 4
  localparam logic [2:0] SLOT_ID0   = 3'd0;
  localparam logic [2:0] SLOT_ID1   = 3'd1;
  localparam logic [2:0] SLOT_ID2   = 3'd2;
  localparam logic [2:0] SLOT_ID3   = 3'd3;
  localparam logic [2:0] SLOT_DATA  = 3'd4;
  localparam logic [2:0] SLOT_STAT  = 3'd5;
  localparam logic [2:0] SLOT_DIVLO = 3'd6;
  localparam logic [2:0] SLOT_DIVHI = 3'd7;

  // status bit positions
  localparam int ST_FERR  = 0;
  localparam int ST_OERR  = 1;
  localparam int ST_RXIE  = 2;
  localparam int ST_FULL  = 3;
  localparam int ST_ONE   = 4;
  localparam int ST_EMPTY = 5;
  localparam int ST_TXIE  = 6;
  localparam int ST_THRE  = 7;
endpackage

// File: rtl/sprt_rx_fifo.sv
module sprt_rx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= bump(wp_q);
      if (pop)  rp_q <= bump(rp_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign head  = mem[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/sprt_tx_serial.sv
module sprt_tx_serial #(
  parameter int DIV_W = 16,
  parameter int OVS   = 4,
  parameter int W     = 8,
  localparam int FRAME = W + 2,
  localparam int SW    = $clog2(OVS),
  localparam int BW    = $clog2(FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_byte,
  output logic             txd,
  output logic             busy
);
  logic [DIV_W-1:0] pre_q;
  logic [SW-1:0]    sub_q;
  logic [BW-1:0]    bit_q;
  logic [FRAME-1:0] sh_q;
  logic             busy_q;
  logic             tick;

  assign in_ready = !busy_q;
  assign tick     = (pre_q >= div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      sub_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '1;
      busy_q <= 1'b0;
    end else if (in_valid && !busy_q) begin
      sh_q   <= {1'b1, in_byte, 1'b0};
      busy_q <= 1'b1;
      pre_q  <= '0;
      sub_q  <= '0;
      bit_q  <= '0;
    end else if (busy_q) begin
      if (tick) begin
        pre_q <= '0;
        if (sub_q == SW'(OVS - 1)) begin
          sub_q <= '0;
          sh_q  <= {1'b1, sh_q[FRAME-1:1]};
          if (bit_q == BW'(FRAME - 1)) busy_q <= 1'b0;
          else                         bit_q  <= bit_q + 1'b1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import sprt_pkg::*;
#(
  parameter int          RX_DEPTH = 4,
  parameter logic [31:0] ID_WORD  = 32'h07C0_315A,
  localparam int CW = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_frame_bad,
  output logic              irq,
  output logic              txd
);
  logic [2:0]        slot;
  logic              aligned;
  logic [CW-1:0]     rx_cnt;
  logic [BYTE_W-1:0] rx_head;
  logic              rx_empty, rx_full, rx_push, rx_pop;
  logic              rxie_q, txie_q, ferr_q, oerr_q;
  logic [15:0]       div_q;
  logic              hold_full_q, hold_take, data_wr, hold_load;
  logic [BYTE_W-1:0] hold_byte_q, last_q, rd_data_q, rd_mux, stat;
  logic              tx_ready, tx_busy, stat_wr;

  assign slot    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  assign rx_empty = (rx_cnt == '0);
  assign rx_full  = (rx_cnt == CW'(RX_DEPTH));
  assign rx_ready = !rx_full;
  assign rx_push  = rx_valid && !rx_full;
  assign rx_pop   = bus_rd && aligned && slot == SLOT_DATA && !rx_empty;

  sprt_rx_fifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .head(rx_head), .count(rx_cnt)
  );

  assign data_wr   = bus_wr && aligned && slot == SLOT_DATA;
  assign hold_load = data_wr && !hold_full_q;
  assign hold_take = hold_full_q && tx_ready;
  assign stat_wr   = bus_wr && aligned && slot == SLOT_STAT;

  sprt_tx_serial #(.DIV_W(16), .OVS(4), .W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .div(div_q), .in_valid(hold_full_q),
    .in_ready(tx_ready), .in_byte(hold_byte_q), .txd(txd), .busy(tx_busy)
  );

  always_comb begin
    stat           = '0;
    stat[ST_FERR]  = ferr_q;
    stat[ST_OERR]  = oerr_q;
    stat[ST_RXIE]  = rxie_q;
    stat[ST_FULL]  = rx_full;
    stat[ST_ONE]   = (rx_cnt == CW'(RX_DEPTH - 1));
    stat[ST_EMPTY] = rx_empty;
    stat[ST_TXIE]  = txie_q;
    stat[ST_THRE]  = !hold_full_q;
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (slot)
        SLOT_ID0:   rd_mux = ID_WORD[7:0];
        SLOT_ID1:   rd_mux = ID_WORD[15:8];
        SLOT_ID2:   rd_mux = ID_WORD[23:16];
        SLOT_ID3:   rd_mux = ID_WORD[31:24];
        SLOT_DATA:  rd_mux = rx_empty ? last_q : rx_head;
        SLOT_STAT:  rd_mux = stat;
        SLOT_DIVLO: rd_mux = div_q[7:0];
        default:    rd_mux = div_q[15:8];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxie_q      <= 1'b0;
      txie_q      <= 1'b0;
      ferr_q      <= 1'b0;
      oerr_q      <= 1'b0;
      div_q       <= '0;
      hold_full_q <= 1'b0;
      hold_byte_q <= '0;
      last_q      <= '0;
      rd_data_q   <= '0;
    end else begin
      if (bus_rd) rd_data_q <= rd_mux;
      if (rx_pop) last_q <= rx_head;
      if (hold_load) begin
        hold_full_q <= 1'b1;
        hold_byte_q <= bus_wdata;
      end else if (hold_take) begin
        hold_full_q <= 1'b0;
      end
      if (stat_wr) begin
        rxie_q <= bus_wdata[ST_RXIE];
        txie_q <= bus_wdata[ST_TXIE];
      end
      ferr_q <= (ferr_q && !(stat_wr && !bus_wdata[ST_FERR])) ||
                (rx_push && rx_frame_bad);
      oerr_q <= (oerr_q && !(stat_wr && !bus_wdata[ST_OERR])) ||
                (rx_valid && rx_full);
      if (bus_wr && aligned && slot == SLOT_DIVLO) div_q[7:0]  <= bus_wdata;
      if (bus_wr && aligned && slot == SLOT_DIVHI) div_q[15:8] <= bus_wdata;
    end
  end

  assign bus_rdata = rd_data_q;
  assign irq = (rxie_q && (!rx_empty || ferr_q || oerr_q)) ||
               (txie_q && !hold_full_q);
endmodule

// File: rtl/sprt_checker.sv
module sprt_checker #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          oerr,
  input logic [CW-1:0] count,
  input logic          txd,
  input logic          tx_busy,
  input logic          txie,
  input logic          hold_full,
  input logic          irq,
  input logic          bus_rd,
  input logic [7:0]    bus_rdata,
  input logic          data_wr,
  input logic [7:0]    hold_byte
);
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata)); // R1
  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R3
  AST_OVERRUN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> oerr); // R5
  AST_READY_WITH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (count < CW'(DEPTH)) |-> rx_ready); // R5
  AST_FULL_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && hold_full) |=> $stable(hold_byte)); // R7
  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd); // R8
  AST_TX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (txie && !hold_full) |-> irq); // R9
endmodule

bind serial_port_regs sprt_checker #(.DEPTH(RX_DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .oerr(oerr_q), .count(rx_cnt), .txd(txd), .tx_busy(tx_busy),
  .txie(txie_q), .hold_full(hold_full_q), .irq(irq), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .data_wr(data_wr), .hold_byte(hold_byte_q)
);

// File: tb/serial_port_regs_tb.sv
module serial_port_regs_tb;
  localparam logic [31:0] IDW = 32'h07C0_315A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_valid = 1'b0, rx_frame_bad = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rx_ready, irq, txd;

  int checks = 0, errors = 0, frames = 0, bit_p = 4;
  bit done = 1'b0, mon_busy = 1'b0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  serial_port_regs #(.RX_DEPTH(4), .ID_WORD(IDW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte),
    .rx_frame_bad(rx_frame_bad), .irq(irq), .txd(txd)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, input logic bad);
    @(negedge clk); rx_byte = b; rx_frame_bad = bad; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0; rx_frame_bad = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // scoreboard monitor: decode frames on txd, compare with queue
  initial begin
    logic [7:0] got;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        mon_busy = 1'b1;
        repeat (bit_p / 2) @(negedge clk);
        chk("R8 start bit", {7'd0, txd}, 8'h00);
        for (int i = 0; i < 8; i++) begin
          repeat (bit_p) @(negedge clk);
          got[i] = txd;
        end
        repeat (bit_p) @(negedge clk);
        chk("R8 stop bit", {7'd0, txd}, 8'h01);
        if (exp_q.size() == 0) chk("R7 unexpected frame", got, 8'hxx);
        else chk("R8 frame byte", got, exp_q.pop_front());
        frames++;
        mon_busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(5'd20, d); chk("R10 status after reset", d, 8'hA0);
    chk("R10 irq low", {7'd0, irq}, 8'h00);
    chk("R10 txd idle high", {7'd0, txd}, 8'h01);
    // R1 id bytes and write immunity
    rd(5'd0, d);  chk("R1 id0", d, IDW[7:0]);
    rd(5'd4, d);  chk("R1 id1", d, IDW[15:8]);
    rd(5'd8, d);  chk("R1 id2", d, IDW[23:16]);
    rd(5'd12, d); chk("R1 id3", d, IDW[31:24]);
    wr(5'd0, 8'hFF); rd(5'd0, d); chk("R1 id0 after write", d, IDW[7:0]);
    // R2 divisor
    rd(5'd24, d); chk("R2 divisor low reset", d, 8'h00);
    wr(5'd24, 8'h34); wr(5'd28, 8'h12);
    rd(5'd24, d); chk("R2 divisor low", d, 8'h34);
    rd(5'd28, d); chk("R2 divisor high", d, 8'h12);
    wr(5'd24, 8'h01); wr(5'd28, 8'h00); bit_p = 8;
    // R3 / R5 fifo flags
    push(8'h11, 1'b0); push(8'h22, 1'b0); push(8'h33, 1'b0);
    rd(5'd20, d); chk("R3 one slot left", d, 8'h90);
    push(8'h44, 1'b0);
    rd(5'd20, d); chk("R3 full", d, 8'h88);
    chk("R5 ready low when full", {7'd0, rx_ready}, 8'h00);
    push(8'h55, 1'b0);
    rd(5'd20, d); chk("R5 overrun flagged", d, 8'h8A);
    wr(5'd20, 8'hBA);
    rd(5'd20, d); chk("R3 R6 flag-bit writes ignored, 1 keeps", d, 8'h8A);
    wr(5'd20, 8'h00);
    rd(5'd20, d); chk("R6 overrun cleared", d, 8'h88);
    // R4 pop order and empty read
    rd(5'd16, d); chk("R4 pop 1", d, 8'h11);
    rd(5'd16, d); chk("R4 pop 2", d, 8'h22);
    rd(5'd16, d); chk("R4 pop 3", d, 8'h33);
    rd(5'd16, d); chk("R4 pop 4 (overrun byte dropped)", d, 8'h44);
    rd(5'd16, d); chk("R4 empty read returns last", d, 8'h44);
    rd(5'd20, d); chk("R4 no underflow", d, 8'hA0);
    // R6 frame error
    push(8'h66, 1'b1);
    rd(5'd20, d); chk("R6 frame error set", d, 8'h81);
    wr(5'd20, 8'h01);
    rd(5'd20, d); chk("R6 write 1 keeps", d, 8'h81);
    wr(5'd20, 8'h00);
    rd(5'd20, d); chk("R6 write 0 clears", d, 8'h80);
    rd(5'd16, d); chk("R6 byte kept", d, 8'h66);
    // R9 interrupt
    wr(5'd20, 8'h04);
    chk("R9 rx enable, no data", {7'd0, irq}, 8'h00);
    push(8'h77, 1'b0);
    chk("R9 rx data irq", {7'd0, irq}, 8'h01);
    rd(5'd16, d); chk("R9 irq after pop", {7'd0, irq}, 8'h00);
    wr(5'd20, 8'h44);
    chk("R9 tx empty irq", {7'd0, irq}, 8'h01);
    wr(5'd20, 8'h00);
    chk("R9 all disabled", {7'd0, irq}, 8'h00);
    // R7 / R8 transmit: X taken, Y dropped (stage full), Z taken
    @(negedge clk); bus_addr = 5'd16; bus_wr = 1'b1; bus_wdata = 8'hA5;
    exp_q.push_back(8'hA5);
    @(negedge clk); bus_wdata = 8'hFF;
    @(negedge clk); bus_wdata = 8'h3C; exp_q.push_back(8'h3C);
    @(negedge clk); bus_wr = 1'b0;
    rd(5'd20, d); chk("R7 holding stage full", d, 8'h20);
    while (exp_q.size() != 0 || mon_busy) @(negedge clk);
    chk("R7 frames sent", 8'(frames), 8'd2);
    rd(5'd20, d); chk("R7 holding empty again", d, 8'hA0);
    finish_run();
  end
endmodule